// File: doc/BRIEF.md
# VCO Autocalibration Sequencer

This block controls the calibration of an integer-N local-oscillator synthesizer. Software sets the divider and target registers first. A write to the calibration register then starts a fixed sequence, and that register must be written last. The sequence has three stages:

1. It picks a half-rate post-divider code from the target frequency.
2. It searches the VCO band by successive approximation, from the most significant bit down.
3. It raises the oscillator amplitude code until the analog side reports a good swing.

During the band search the VCO tune input is taken off the loop filter and tied to an internal reference. The sequencer then hands the input back to the loop filter so that normal loop action resumes.

Each band trial lasts a fixed window of PFD reference events. Inside the window the sequencer counts feedback-divider events. If the feedback count is at or below the window length, the oscillator is too slow and the trial bit is kept. If the count is above the window length, the bit is cleared. A write to the calibration register during a run discards the partial result and starts again from the beginning.

Top module: `vco_cal_seq`

## Requirements
- R1: A cycle with `reg_wr` high and `reg_addr` equal to 3 starts calibration. `busy` is high in the next cycle, and `band_code` and `amp_code` are both 0 in that cycle.
- R2: A write to any address other than 3 while idle does not start calibration. `busy` stays low, and `band_code`, `amp_code` and `div_code` keep their values.
- R3: A write to address 3 during a run restarts the whole sequence. The `tgt_freq` value captured by the new write is used, and the final codes match a fresh calibration for that value.
- R4: The divider code is computed first. It is the largest code k in 0..12 with `tgt_freq*(4+k) <= 560`, clamped to 0 when no such k exists; a `tgt_freq` of 0 gives 12. Code k stands for a divide ratio of 2.0+0.5k. The code is valid two cycles after the triggering write and holds until the next start.
- R5: Each band trial spans exactly 5 `ref_tick` events. The full search over the 4-bit band code therefore covers exactly 20 `ref_tick` events while `tune_ref` is high.
- R6: `tune_ref` (1 = tune input on the internal reference, 0 = on the loop filter) is high only during the band search. It is low at reset, during divider selection, during amplitude stepping and after completion.
- R7: Each band bit is first tried as 1. It is kept when the number of `fb_tick` events inside its window is at most 5, and cleared when the count is above 5.
- R8: After the band search, `amp_code` starts at 0 and increments by one on each `ref_tick` while `amp_ok` is low. It stops at the first `ref_tick` with `amp_ok` high, or at the saturated value 7.
- R9: `busy` stays high from the triggering write until the last step. It is low while `done` is high. `done` is high for exactly one cycle.
- R10: After reset, `busy`, `done`, `tune_ref`, `band_code`, `amp_code` and `div_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| tgt_freq | input | 8 | Programmed target frequency, captured by the calibration write |
| ref_tick | input | 1 | One-cycle pulse per PFD reference-divider event |
| fb_tick | input | 1 | One-cycle pulse per feedback-divider event |
| amp_ok | input | 1 | Oscillator amplitude is sufficient |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |
| tune_ref | output | 1 | 1 = tune input on the internal reference, 0 = on the loop filter |
| band_code | output | 4 | Selected VCO band |
| amp_code | output | 3 | Selected amplitude code |
| div_code | output | 4 | Half-rate divider code (ratio 2.0+0.5*code) |

## Verification
The assertions check these rules on every cycle:
- A calibration write raises `busy` with cleared band and amplitude codes.
- A write to another address leaves the block idle with its codes unchanged.
- `tune_ref` is never high outside a run.
- `done` is a single-cycle pulse that follows a busy period.

Only the bench scenarios can show the following. The successive-approximation search lands on the intended band for every one of the 16 band positions. Each trial lasts exactly five reference events. Amplitude stepping stops at the right code or saturates. The divider lookup is correct over all 256 target values. A mid-run write discards the partial result.

// File: rtl/vco_cal_pkg.sv
package vco_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DIVSEL = 3'd1,
    ST_BAND   = 3'd2,
    ST_AMP    = 3'd3,
    ST_DONE   = 3'd4
  } cal_state_e;

  // Number of half-rate divider codes: ratios 2.0 .. 8.0 in 0.5 steps.
  localparam int unsigned DIV_CODES = 13;

endpackage

// File: rtl/vco_cal_divsel.sv
// Divider-code lookup: largest code k with tgt*(4+k) <= LIMIT_X2.
module vco_cal_divsel #(
  parameter int unsigned FREQ_W   = 8,
  parameter int unsigned DIV_W    = 4,
  parameter int unsigned LIMIT_X2 = 560
) (
  input  logic [FREQ_W-1:0] tgt,
  output logic [DIV_W-1:0]  code
);
  import vco_cal_pkg::*;

  localparam int unsigned PROD_W = FREQ_W + DIV_W + 2;

  logic [DIV_CODES-1:0] fits;

  // One comparator per candidate code.
  for (genvar k = 0; k < DIV_CODES; k++) begin : g_fit
    logic [PROD_W-1:0] prod;
    assign prod    = PROD_W'(tgt) * PROD_W'(4 + k);
    assign fits[k] = (prod <= PROD_W'(LIMIT_X2));
  end

  // The fit vector is monotone, so the highest set index is the answer.
  always_comb begin
    code = '0;
    for (int k = 1; k < DIV_CODES; k++) begin
      if (fits[k]) code = DIV_W'(k);
    end
  end

endmodule

// File: rtl/vco_cal_window.sv
// Counts feedback events across a window of WIN_CYC reference events.
module vco_cal_window #(
  parameter int unsigned WIN_CYC = 5,
  parameter int unsigned REF_W   = 3,
  parameter int unsigned FB_W    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            ref_tick,
  input  logic            fb_tick,
  output logic            win_done,
  output logic            too_fast
);
  logic [REF_W-1:0] ref_cnt_q, ref_cnt_d;
  logic [FB_W-1:0]  fb_cnt_q,  fb_cnt_d;
  logic [FB_W:0]    fb_total;
  logic             cnt_en;

  assign fb_total = {1'b0, fb_cnt_q} + (FB_W+1)'(fb_tick);
  assign win_done = en && ref_tick && (ref_cnt_q == REF_W'(WIN_CYC - 1));
  assign too_fast = (fb_total > (FB_W+1)'(WIN_CYC));
  assign cnt_en   = en || (ref_cnt_q != '0) || (fb_cnt_q != '0);

  always_comb begin
    ref_cnt_d = ref_cnt_q;
    fb_cnt_d  = fb_cnt_q;
    if (!en || win_done) begin
      ref_cnt_d = '0;
      fb_cnt_d  = '0;
    end else begin
      if (ref_tick) ref_cnt_d = ref_cnt_q + 1'b1;
      if (fb_tick && (fb_cnt_q != '1)) fb_cnt_d = fb_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt_q <= '0;
      fb_cnt_q  <= '0;
    end else if (cnt_en) begin
      ref_cnt_q <= ref_cnt_d;
      fb_cnt_q  <= fb_cnt_d;
    end
  end

endmodule

// File: rtl/vco_cal_fsm.sv
// Sequencer: divider select, SAR band search, amplitude ramp.
module vco_cal_fsm #(
  parameter int unsigned FREQ_W = 8,
  parameter int unsigned BAND_W = 4,
  parameter int unsigned AMP_W  = 3,
  parameter int unsigned DIV_W  = 4,
  parameter int unsigned BIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] tgt_freq,
  input  logic [DIV_W-1:0]  div_lookup,
  input  logic              win_done,
  input  logic              too_fast,
  input  logic              ref_tick,
  input  logic              amp_ok,
  output logic [FREQ_W-1:0] tgt_q,
  output logic              in_band,
  output logic              busy,
  output logic              done,
  output logic [BAND_W-1:0] band_q,
  output logic [AMP_W-1:0]  amp_q,
  output logic [DIV_W-1:0]  div_q
);
  import vco_cal_pkg::*;

  cal_state_e        state_q, state_d;
  logic [BIDX_W-1:0] bit_q, bit_d;
  logic [BAND_W-1:0] band_d;
  logic [AMP_W-1:0]  amp_d;
  logic [DIV_W-1:0]  div_d;
  logic [FREQ_W-1:0] tgt_d;
  logic              reg_en;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    band_d  = band_q;
    amp_d   = amp_q;
    div_d   = div_q;
    tgt_d   = tgt_q;
    if (start) begin
      state_d = ST_DIVSEL;
      band_d  = '0;
      amp_d   = '0;
      tgt_d   = tgt_freq;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_DIVSEL: begin
          div_d             = div_lookup;
          bit_d             = BIDX_W'(BAND_W - 1);
          band_d            = '0;
          band_d[BAND_W-1]  = 1'b1;
          state_d           = ST_BAND;
        end
        ST_BAND: begin
          if (win_done) begin
            if (too_fast) band_d[bit_q] = 1'b0;
            if (bit_q == '0) begin
              state_d = ST_AMP;
            end else begin
              bit_d                 = bit_q - 1'b1;
              band_d[bit_q - 1'b1]  = 1'b1;
            end
          end
        end
        ST_AMP: begin
          if (ref_tick) begin
            if (amp_ok || (amp_q == '1)) state_d = ST_DONE;
            else                         amp_d   = amp_q + 1'b1;
          end
        end
        ST_DONE: state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign reg_en = start || (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      band_q  <= '0;
      amp_q   <= '0;
      div_q   <= '0;
      tgt_q   <= '0;
    end else if (reg_en) begin
      state_q <= state_d;
      bit_q   <= bit_d;
      band_q  <= band_d;
      amp_q   <= amp_d;
      div_q   <= div_d;
      tgt_q   <= tgt_d;
    end
  end

  assign in_band = (state_q == ST_BAND);
  assign busy    = (state_q == ST_DIVSEL) || (state_q == ST_BAND) || (state_q == ST_AMP);
  assign done    = (state_q == ST_DONE);

endmodule

// File: rtl/vco_cal_seq.sv
module vco_cal_seq #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned CAL_ADDR = 3,
  parameter int unsigned FREQ_W   = 8,
  parameter int unsigned BAND_W   = 4,
  parameter int unsigned AMP_W    = 3,
  parameter int unsigned DIV_W    = 4,
  parameter int unsigned WIN_CYC  = 5,
  parameter int unsigned LIMIT_X2 = 560
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [FREQ_W-1:0] tgt_freq,
  input  logic              ref_tick,
  input  logic              fb_tick,
  input  logic              amp_ok,
  output logic              busy,
  output logic              done,
  output logic              tune_ref,
  output logic [BAND_W-1:0] band_code,
  output logic [AMP_W-1:0]  amp_code,
  output logic [DIV_W-1:0]  div_code
);
  localparam int unsigned BIDX_W = (BAND_W > 1) ? $clog2(BAND_W) : 1;
  localparam int unsigned REF_W  = $clog2(WIN_CYC + 1);
  localparam int unsigned FB_W   = $clog2(2 * WIN_CYC + 2);

  logic              start;
  logic              in_band;
  logic              win_done;
  logic              too_fast;
  logic [FREQ_W-1:0] tgt_q;
  logic [DIV_W-1:0]  div_lookup;

  assign start = reg_wr && (reg_addr == ADDR_W'(CAL_ADDR));

  vco_cal_divsel #(
    .FREQ_W(FREQ_W), .DIV_W(DIV_W), .LIMIT_X2(LIMIT_X2)
  ) u_divsel (
    .tgt  (tgt_q),
    .code (div_lookup)
  );

  vco_cal_window #(
    .WIN_CYC(WIN_CYC), .REF_W(REF_W), .FB_W(FB_W)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (in_band),
    .ref_tick (ref_tick),
    .fb_tick  (fb_tick),
    .win_done (win_done),
    .too_fast (too_fast)
  );

  vco_cal_fsm #(
    .FREQ_W(FREQ_W), .BAND_W(BAND_W), .AMP_W(AMP_W),
    .DIV_W(DIV_W), .BIDX_W(BIDX_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .tgt_freq   (tgt_freq),
    .div_lookup (div_lookup),
    .win_done   (win_done),
    .too_fast   (too_fast),
    .ref_tick   (ref_tick),
    .amp_ok     (amp_ok),
    .tgt_q      (tgt_q),
    .in_band    (in_band),
    .busy       (busy),
    .done       (done),
    .band_q     (band_code),
    .amp_q      (amp_code),
    .div_q      (div_code)
  );

  assign tune_ref = in_band;

endmodule

// File: rtl/vco_cal_chk.sv
module vco_cal_chk #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned CAL_ADDR = 3,
  parameter int unsigned BAND_W   = 4,
  parameter int unsigned AMP_W    = 3,
  parameter int unsigned DIV_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              busy,
  input logic              done,
  input logic              tune_ref,
  input logic [BAND_W-1:0] band_code,
  input logic [AMP_W-1:0]  amp_code,
  input logic [DIV_W-1:0]  div_code
);
  logic trig;
  assign trig = reg_wr && (reg_addr == ADDR_W'(CAL_ADDR));

  // R1
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (busy && (band_code == '0) && (amp_code == '0)));

  // R2
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !trig) |=> (!busy && $stable(band_code) && $stable(amp_code) && $stable(div_code)));

  // R6
  tune_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tune_ref |-> busy);

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind vco_cal_seq vco_cal_chk #(
  .ADDR_W(ADDR_W), .CAL_ADDR(CAL_ADDR), .BAND_W(BAND_W),
  .AMP_W(AMP_W), .DIV_W(DIV_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .busy      (busy),
  .done      (done),
  .tune_ref  (tune_ref),
  .band_code (band_code),
  .amp_code  (amp_code),
  .div_code  (div_code)
);

// File: tb/tb_vco_cal_seq.sv
module tb_vco_cal_seq;
  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] tgt_freq;
  logic       ref_tick;
  logic       fb_tick;
  logic       amp_ok;
  logic       busy, done, tune_ref;
  logic [3:0] band_code;
  logic [2:0] amp_code;
  logic [3:0] div_code;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  int bstar = 0;
  int astar = 8;

  vco_cal_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .tgt_freq(tgt_freq), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .amp_ok(amp_ok), .busy(busy), .done(done), .tune_ref(tune_ref),
    .band_code(band_code), .amp_code(amp_code), .div_code(div_code)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural VCO: 8-cycle reference period. Feedback is half rate
  // below the ideal band, equal at it, double rate above it.
  initial begin
    int ph;
    int ridx;
    ph = 7; ridx = 0;
    ref_tick = 1'b0; fb_tick = 1'b0; amp_ok = 1'b0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 8;
      ref_tick = (ph == 0);
      if (ph == 0) ridx++;
      if (int'(band_code) < bstar)       fb_tick = (ph == 0) && ridx[0];
      else if (int'(band_code) == bstar) fb_tick = (ph == 0);
      else                               fb_tick = (ph == 0) || (ph == 4);
      amp_ok = (int'(amp_code) >= astar);
    end
  end

  function automatic int exp_div(input int t);
    int q;
    if (t == 0) return 12;
    q = 560 / t - 4;
    if (q > 12) q = 12;
    if (q < 0)  q = 0;
    return q;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  task automatic write(input logic [2:0] a, input logic [7:0] t);
    @(negedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; tgt_freq = t;
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  // Waits for done, counting reference events seen with tune_ref high.
  task automatic wait_done(output int ticks);
    int guard;
    ticks = 0; guard = 0;
    while (done !== 1'b1 && guard < 4000) begin
      if (tune_ref && ref_tick) ticks++;
      @(negedge clk); #1;
      guard++;
    end
    if (guard >= 4000) check("R9 done timeout", 0, 1);
  endtask

  task automatic run_cal(input int t, input int b, input int a, input bit full);
    int ticks;
    int ea;
    bstar = b; astar = a;
    write(3'd3, 8'(t));
    // R1: busy in the cycle after the write
    check("R1 busy after start", int'(busy), 1);
    wait_done(ticks);
    ea = (a > 7) ? 7 : a;
    // R9: busy low with done
    check("R9 busy low at done", int'(busy), 0);
    // R7: SAR result
    check("R7 band code", int'(band_code), b);
    // R8: amplitude ramp result
    check("R8 amp code", int'(amp_code), ea);
    // R4: divider code
    check("R4 div code", int'(div_code), exp_div(t));
    if (full) begin
      // R5: 4 trials x 5 reference events
      check("R5 ref ticks in band search", ticks, 20);
      // R6: tune input back on loop filter
      check("R6 tune_ref low at done", int'(tune_ref), 0);
      @(negedge clk); #1;
      // R9: single-cycle done pulse
      check("R9 done one cycle", int'(done), 0);
    end
  endtask

  initial begin
    int ticks;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; tgt_freq = '0;
    repeat (3) @(negedge clk);
    #1;
    // R10: reset state
    check("R10 busy", int'(busy), 0);
    check("R10 done", int'(done), 0);
    check("R10 tune_ref", int'(tune_ref), 0);
    check("R10 band", int'(band_code), 0);
    check("R10 amp", int'(amp_code), 0);
    check("R10 div", int'(div_code), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7 / R8: every band against a range of amplitude thresholds
    for (int b = 0; b < 16; b++) begin
      for (int a = 0; a < 9; a++) begin
        run_cal(40 + b * 7 + a, b, a, (a == 0 || a == 8));
      end
    end

    // R2: writes elsewhere are ignored
    for (int ad = 0; ad < 8; ad++) begin
      if (ad != 3) begin
        write(3'(ad), 8'd17);
        repeat (6) @(negedge clk);
        #1;
        check("R2 busy stays low", int'(busy), 0);
        check("R2 band unchanged", int'(band_code), 15);
        check("R2 amp unchanged", int'(amp_code), 7);
        check("R2 div unchanged", int'(div_code), exp_div(40 + 15 * 7 + 8));
      end
    end

    // R4: divider lookup over every target, sampled two cycles after write
    for (int t = 0; t < 256; t++) begin
      write(3'd3, 8'(t));
      @(negedge clk); #1;
      check("R4 div sweep", int'(div_code), exp_div(t));
    end
    wait_done(ticks);

    // R3: restart mid-search with a different target and band
    bstar = 12; astar = 8;
    write(3'd3, 8'd200);
    repeat (60) @(negedge clk);
    #1;
    check("R3 tune_ref during search", int'(tune_ref), 1);
    run_cal(90, 5, 3, 1'b1);

    // R3: restart during the amplitude ramp
    bstar = 9; astar = 8;
    write(3'd3, 8'd30);
    while (!(busy && !tune_ref && cyc > 0 && amp_code != 0)) begin
      @(negedge clk); #1;
    end
    run_cal(120, 3, 2, 1'b1);

    finish_run();
  end

  initial begin
    wait (cyc >= 150000);
    check("watchdog expired", 0, 1);
    finish_run();
  end

endmodule